// File: doc/BRIEF.md
# Bus Cycle Termination Unit

This block closes every bus access that a chip select opens. When an access starts, it looks up a wait-state count for the selected chip select. It then acknowledges each data beat once that many wait cycles have gone by. An access may be a single beat or a burst of up to four beats, and every beat gets its own acknowledge.

An access can also end abnormally through a transfer error. The error can come from an external error input or from an internal bus monitor. The monitor counts clocks from the start of the access and fires when a programmed limit is reached. Any error ends the access in the cycle it appears, and the beats that have not yet run are dropped.

The first error is kept in a small status record. The record holds the chip select and the beat index of the aborted access until it is cleared.

Top module: `bus_term_unit`

## Requirements
- R1: After reset, `data_ack`, `err_ack` and `cyc_done` are low and `err_valid` is low.
- R2: The wait count for chip select i is `cfg_ws[4i+3:4i]`, read when the access starts. With count W, a beat is acknowledged on the (W+1)-th clock after the edge that starts it, so W=0 acknowledges in the first busy cycle. The wait count restarts for every beat.
- R3: `cyc_len` gives the number of beats minus one (0 to 3). Each beat raises `data_ack` for one cycle, and `cyc_done` rises together with the acknowledge of the last beat.
- R4: `ext_err` high during a busy cycle raises `err_ack` and `cyc_done` in that same cycle. No further beat of that access is acknowledged.
- R5: With `mon_en` high, busy cycles are numbered from 0 starting with the first cycle after the start edge. If the access is still busy at cycle number `mon_limit`, an internal error ends it exactly as in R4.
- R6: If an error and a beat acknowledge fall in the same cycle, only `err_ack` is raised and `data_ack` stays low.
- R7: On the first error while `err_valid` is low, `err_cs` and `err_beat` (the index of the beat being served, counting from 0) are captured and `err_valid` is set. Later errors leave the record unchanged until `err_clr` clears it. If an error and `err_clr` arrive in the same cycle, the new error is recorded.
- R8: `cyc_start` while an access is busy is ignored, and so is `ext_err` while idle. Neither changes the outputs or the error record.
- R9: With `mon_en` low, no internal timeout is raised, whatever `mon_limit` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_start | input | 1 | Starts an access when idle |
| cyc_cs | input | 3 | Chip select of the access |
| cyc_len | input | 2 | Beats minus one |
| ext_err | input | 1 | External transfer error |
| cfg_ws | input | 32 | Wait counts, 4 bits per chip select |
| mon_en | input | 1 | Bus monitor enable |
| mon_limit | input | 10 | Monitor timeout, busy cycle number |
| err_clr | input | 1 | Clears the error record |
| data_ack | output | 1 | Beat acknowledge |
| err_ack | output | 1 | Error acknowledge, ends the access |
| cyc_done | output | 1 | Last cycle of the access |
| err_valid | output | 1 | Error record is valid |
| err_cs | output | 3 | Chip select of the recorded error |
| err_beat | output | 2 | Beat index of the recorded error |

## Verification
Directed accesses cover these cases:
- zero and maximum wait counts, which separate first-cycle acknowledgement from a full per-beat wait;
- four-beat bursts, which show whether the wait count restarts on each beat;
- an external error part way through a burst, and a monitor limit that lands on an acknowledge cycle, which check abort and precedence;
- starts issued while busy and errors issued while idle, which show that ignored inputs stay ignored.

Random accesses then mix chip selects, lengths, monitor settings and error timing. The bench compares each cycle and the error record against a per-cycle model built from the requirements.

// File: rtl/btu_pkg.sv
package btu_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_BUSY = 1'b1} btu_state_e;

  typedef struct packed {
    logic       valid;
    logic [2:0] cs;
    logic [1:0] beat;
  } btu_err_rec_t;
endpackage

// File: rtl/btu_beat_seq.sv
module btu_beat_seq
  import btu_pkg::*;
#(
  parameter int CS_W   = 3,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CS_W-1:0]   cs_in,
  input  logic [BEAT_W-1:0] len_in,
  input  logic              beat_ack,
  input  logic              abort,
  output logic              busy,
  output logic [CS_W-1:0]   cs_q,
  output logic [BEAT_W-1:0] beat_q,
  output logic              last_beat
);
  btu_state_e        st_q, st_d;
  logic [CS_W-1:0]   cs_d;
  logic [BEAT_W-1:0] len_q, len_d, beat_d;
  logic              ld_en;

  assign busy      = (st_q == ST_BUSY);
  assign last_beat = (beat_q == len_q);
  assign ld_en     = start && !busy;

  always_comb begin
    st_d   = st_q;
    cs_d   = cs_q;
    len_d  = len_q;
    beat_d = beat_q;
    if (ld_en) begin
      st_d   = ST_BUSY;
      cs_d   = cs_in;
      len_d  = len_in;
      beat_d = '0;
    end else if (busy) begin
      if (abort) begin
        st_d = ST_IDLE;
      end else if (beat_ack) begin
        if (last_beat) st_d = ST_IDLE;
        else           beat_d = beat_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cs_q   <= '0;
      len_q  <= '0;
      beat_q <= '0;
    end else begin
      st_q   <= st_d;
      cs_q   <= cs_d;
      len_q  <= len_d;
      beat_q <= beat_d;
    end
  end
endmodule

// File: rtl/btu_ws_counter.sv
module btu_ws_counter #(
  parameter int WS_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [WS_W-1:0] ws_in,
  input  logic            busy,
  input  logic            beat_end,
  output logic            hit
);
  logic [WS_W-1:0] lim_q, lim_d;
  logic [WS_W-1:0] cnt_q, cnt_d;
  logic            cnt_en;

  assign hit    = busy && (cnt_q == lim_q);
  assign cnt_en = load || busy;

  always_comb begin
    lim_d = lim_q;
    cnt_d = cnt_q;
    if (load) begin
      lim_d = ws_in;
      cnt_d = '0;
    end else if (beat_end) begin
      cnt_d = '0;
    end else if (!hit) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_q <= '0;
      cnt_q <= '0;
    end else if (cnt_en) begin
      lim_q <= lim_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/btu_bus_monitor.sv
module btu_bus_monitor #(
  parameter int TMO_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             busy,
  input  logic             en,
  input  logic [TMO_W-1:0] limit,
  output logic             timeout
);
  logic [TMO_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             at_max;

  assign at_max  = &cnt_q;
  assign timeout = busy && en && (cnt_q == limit);
  assign cnt_en  = load || (busy && !at_max);

  always_comb begin
    if (load) cnt_d = '0;
    else      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/btu_err_status.sv
module btu_err_status
  import btu_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set,
  input  logic [2:0]   cs_in,
  input  logic [1:0]   beat_in,
  input  logic         clr,
  output btu_err_rec_t rec
);
  btu_err_rec_t rec_d;
  logic         upd_en;

  assign upd_en = clr || (set && !rec.valid);

  always_comb begin
    rec_d = rec;
    if (clr) rec_d.valid = 1'b0;
    if (set && (clr || !rec.valid)) begin
      rec_d.valid = 1'b1;
      rec_d.cs    = cs_in;
      rec_d.beat  = beat_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rec <= '0;
    else if (upd_en) rec <= rec_d;
  end
endmodule

// File: rtl/bus_term_unit.sv
module bus_term_unit
  import btu_pkg::*;
#(
  parameter int NUM_CS    = 8,
  parameter int WS_W      = 4,
  parameter int MAX_BEATS = 4,
  parameter int TMO_W     = 10,
  localparam int CS_W     = $clog2(NUM_CS),
  localparam int BEAT_W   = $clog2(MAX_BEATS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cyc_start,
  input  logic [CS_W-1:0]        cyc_cs,
  input  logic [BEAT_W-1:0]      cyc_len,
  input  logic                   ext_err,
  input  logic [NUM_CS*WS_W-1:0] cfg_ws,
  input  logic                   mon_en,
  input  logic [TMO_W-1:0]       mon_limit,
  input  logic                   err_clr,
  output logic                   data_ack,
  output logic                   err_ack,
  output logic                   cyc_done,
  output logic                   err_valid,
  output logic [CS_W-1:0]        err_cs,
  output logic [BEAT_W-1:0]      err_beat
);
  logic [WS_W-1:0] ws_tab [NUM_CS];
  logic            busy, last_beat, load, ws_hit, tmo;
  logic [CS_W-1:0] cs_q;
  logic [BEAT_W-1:0] beat_q;
  btu_err_rec_t    rec;

  for (genvar g = 0; g < NUM_CS; g++) begin : g_ws
    assign ws_tab[g] = cfg_ws[g*WS_W +: WS_W];
  end

  assign load     = cyc_start && !busy;
  assign err_ack  = busy && (ext_err || tmo);
  assign data_ack = ws_hit && !err_ack;
  assign cyc_done = err_ack || (data_ack && last_beat);

  btu_beat_seq #(.CS_W(CS_W), .BEAT_W(BEAT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(cyc_start), .cs_in(cyc_cs),
    .len_in(cyc_len), .beat_ack(data_ack), .abort(err_ack),
    .busy(busy), .cs_q(cs_q), .beat_q(beat_q), .last_beat(last_beat)
  );

  btu_ws_counter #(.WS_W(WS_W)) u_ws (
    .clk(clk), .rst_n(rst_n), .load(load), .ws_in(ws_tab[cyc_cs]),
    .busy(busy), .beat_end(data_ack || err_ack), .hit(ws_hit)
  );

  btu_bus_monitor #(.TMO_W(TMO_W)) u_mon (
    .clk(clk), .rst_n(rst_n), .load(load), .busy(busy), .en(mon_en),
    .limit(mon_limit), .timeout(tmo)
  );

  btu_err_status u_err (
    .clk(clk), .rst_n(rst_n), .set(err_ack), .cs_in(cs_q),
    .beat_in(beat_q), .clr(err_clr), .rec(rec)
  );

  assign err_valid = rec.valid;
  assign err_cs    = rec.cs;
  assign err_beat  = rec.beat;
endmodule

// File: rtl/btu_checker.sv
module btu_checker #(
  parameter int TMO_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cyc_start,
  input logic [1:0]       cyc_len,
  input logic             ext_err,
  input logic             mon_en,
  input logic [TMO_W-1:0] mon_limit,
  input logic             err_clr,
  input logic             data_ack,
  input logic             err_ack,
  input logic             cyc_done,
  input logic             err_valid,
  input logic [2:0]       err_cs,
  input logic [1:0]       err_beat
);
  logic             in_cyc;
  logic [TMO_W-1:0] ccnt;
  logic [2:0]       acks;
  logic [1:0]       len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_cyc <= 1'b0;
      ccnt   <= '0;
      acks   <= '0;
      len_q  <= '0;
    end else if (!in_cyc) begin
      if (cyc_start) begin
        in_cyc <= 1'b1;
        ccnt   <= '0;
        acks   <= '0;
        len_q  <= cyc_len;
      end
    end else begin
      if (cyc_done) in_cyc <= 1'b0;
      if (!(&ccnt)) ccnt <= ccnt + 1'b1;
      if (data_ack) acks <= acks + 1'b1;
    end
  end

  AST_ACK_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(data_ack && err_ack)); // R6
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_cyc |-> !data_ack && !err_ack && !cyc_done); // R8
  AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_done |=> !data_ack && !err_ack); // R4
  AST_ERR_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    err_ack |-> cyc_done); // R4
  AST_BEAT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    in_cyc && data_ack |-> acks <= {1'b0, len_q}); // R3
  AST_MON_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
    in_cyc && mon_en && ccnt == mon_limit |-> err_ack); // R5
  AST_REC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid && !err_clr |=> err_valid && $stable(err_cs) && $stable(err_beat)); // R7
  AST_REC_SET: assert property (@(posedge clk) disable iff (!rst_n)
    err_ack |=> err_valid); // R7
endmodule

bind bus_term_unit btu_checker #(.TMO_W(TMO_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .cyc_len(cyc_len),
  .ext_err(ext_err), .mon_en(mon_en), .mon_limit(mon_limit),
  .err_clr(err_clr), .data_ack(data_ack), .err_ack(err_ack),
  .cyc_done(cyc_done), .err_valid(err_valid), .err_cs(err_cs),
  .err_beat(err_beat)
);

// File: tb/sim_bus_term_unit.sv
module sim_bus_term_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n, cyc_start, ext_err, mon_en, err_clr;
  logic [2:0]  cyc_cs;
  logic [1:0]  cyc_len;
  logic [31:0] cfg_ws;
  logic [9:0]  mon_limit;
  logic        data_ack, err_ack, cyc_done, err_valid;
  logic [2:0]  err_cs;
  logic [1:0]  err_beat;

  int errors = 0;
  int checks = 0;

  // bench model of the error record
  bit       m_valid = 0;
  bit [2:0] m_cs = 0;
  bit [1:0] m_beat = 0;

  bus_term_unit u0 (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .cyc_cs(cyc_cs),
    .cyc_len(cyc_len), .ext_err(ext_err), .cfg_ws(cfg_ws), .mon_en(mon_en),
    .mon_limit(mon_limit), .err_clr(err_clr), .data_ack(data_ack),
    .err_ack(err_ack), .cyc_done(cyc_done), .err_valid(err_valid),
    .err_cs(err_cs), .err_beat(err_beat)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int ws_of(input int cs);
    return int'(cfg_ws[cs*4 +: 4]);
  endfunction

  task automatic check_rec(input string req);
    chk({req, " err_valid"}, err_valid, m_valid);
    if (m_valid) begin
      chk({req, " err_cs"}, err_cs, m_cs);
      chk({req, " err_beat"}, err_beat, m_beat);
    end
  endtask

  // Runs one access; tea_at is the busy cycle of an external error (-1 none);
  // poke_at is a busy cycle where a stray start is driven (-1 none).
  task automatic run_txn(input int cs, input int len, input int tea_at, input int poke_at);
    int ws, k, bt, wc;
    bit e, a, d;
    ws = ws_of(cs);
    k = 0; bt = 0; wc = 0;
    @(negedge clk);
    cyc_start = 1'b1; cyc_cs = 3'(cs); cyc_len = 2'(len);
    @(posedge clk);
    forever begin
      @(negedge clk);
      cyc_start = (k == poke_at);
      cyc_cs    = (k == poke_at) ? 3'(cs + 1) : 3'(cs);
      cyc_len   = (k == poke_at) ? 2'(len + 1) : 2'(len);
      ext_err   = (k == tea_at);
      e = (k == tea_at) || (mon_en && k == int'(mon_limit));
      a = !e && (wc == ws);
      d = e || (a && bt == len);
      #1;
      chk(e ? "R4/R5 err_ack" : "R9 err_ack", err_ack, e);
      chk((e && wc == ws) ? "R6 data_ack" : "R2 data_ack", data_ack, a);
      chk("R3 cyc_done", cyc_done, d);
      if (e && !m_valid) begin m_valid = 1; m_cs = 3'(cs); m_beat = 2'(bt); end
      if (a) begin bt++; wc = 0; end else wc++;
      k++;
      if (d || k > 2000) break;
      @(posedge clk);
    end
    @(negedge clk);
    cyc_start = 1'b0; ext_err = 1'b0;
    #1;
    chk("R8 idle after done", data_ack | err_ack | cyc_done, 0);
    check_rec("R7");
  endtask

  task automatic clear_rec();
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
    m_valid = 0;
    #1; chk("R7 cleared", err_valid, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; cyc_start = 0; cyc_cs = 0; cyc_len = 0; ext_err = 0;
    mon_en = 0; mon_limit = 0; err_clr = 0;
    cfg_ws = 32'hF3210570; // cs0=0 cs1=7 cs2=5 cs3=0 cs4=1 cs5=2 cs6=3 cs7=15
    repeat (3) @(posedge clk);
    #1;
    chk("R1 data_ack", data_ack, 0);
    chk("R1 err_ack", err_ack, 0);
    chk("R1 cyc_done", cyc_done, 0);
    chk("R1 err_valid", err_valid, 0);
    @(negedge clk); rst_n = 1'b1;

    // R2: zero wait, single beat; maximum wait four-beat burst
    run_txn(0, 0, -1, -1);
    run_txn(7, 3, -1, -1);
    // R2/R3: per-beat restart with a stray start mid-access (R8)
    run_txn(2, 3, -1, 4);
    // R4: external error during beat 1 of a burst
    run_txn(4, 3, 3, -1);
    // R7: second error does not overwrite record
    run_txn(6, 2, 1, -1);
    clear_rec();
    // R6: error in the acknowledge cycle
    run_txn(6, 1, 3, -1);
    clear_rec();
    // R5: monitor hits during beat 1 (ws=3, limit 5)
    mon_en = 1; mon_limit = 10'd5;
    run_txn(6, 3, -1, -1);
    clear_rec();
    // R5/R6: monitor limit equals acknowledge cycle
    mon_limit = 10'd3;
    run_txn(6, 0, -1, -1);
    clear_rec();
    // R9: disabled monitor with small limit
    mon_en = 0; mon_limit = 10'd0;
    run_txn(1, 3, -1, -1);
    // R8: external error while idle is ignored
    @(negedge clk); ext_err = 1'b1; #1;
    chk("R8 err_ack idle", err_ack, 0);
    @(negedge clk); ext_err = 1'b0; #1;
    chk("R8 err_valid idle", err_valid, 0);
    // R7: error and clear in same cycle records the new error
    run_txn(5, 0, 0, -1);
    @(negedge clk); err_clr = 1'b1; mon_en = 0;
    cyc_start = 1'b1; cyc_cs = 3'd3; cyc_len = 2'd0;
    @(negedge clk); cyc_start = 1'b0; ext_err = 1'b1; err_clr = 1'b1;
    #1; chk("R4 err_ack", err_ack, 1);
    @(negedge clk); ext_err = 1'b0; err_clr = 1'b0; #1;
    chk("R7 set wins valid", err_valid, 1);
    chk("R7 set wins cs", err_cs, 3);
    m_valid = 1; m_cs = 3; m_beat = 0;
    clear_rec();

    // random mix
    for (int i = 0; i < 200; i++) begin
      int cs, len, tea, poke;
      cfg_ws = $urandom();
      cs   = int'($urandom_range(0, 7));
      len  = int'($urandom_range(0, 3));
      tea  = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 40)) : -1;
      poke = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 10)) : -1;
      mon_en    = $urandom_range(0, 1) == 1;
      mon_limit = 10'($urandom_range(0, 70));
      run_txn(cs, len, tea, poke);
      if ($urandom_range(0, 2) == 0) clear_rec();
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule